// File: doc/BRIEF.md
# Bit-Serial Multiplier Array

This block multiplies an N-bit unsigned multiplicand, held in parallel on its input, by an N-bit unsigned multiplier that arrives one bit per clock, least significant bit first. It is a row of N identical cells. Each cell owns one multiplicand bit, gates it with the multiplier bit that all cells see in the same cycle, and adds the result to the running sum handed over by its upper neighbour and to a carry that it keeps for itself. The sum from the cell holding multiplicand bit 0 is registered and leaves the block as the product stream.

An operation takes 2N slots, one slot per clock. In the first N slots the caller drives multiplier bits 0 to N-1. In the next N slots the caller drives zero, which pushes the upper half of the product out of the array. The 2N-bit product appears least significant bit first, one clock behind the slot that forms it. The multiplicand must stay unchanged while the multiplier bits are being fed. After the last flush slot the array holds no residue, so the next operation can begin in the following slot. The block adds no sequencing logic; a caller or a small counter in a wrapper drives the slots.

Top module: `spm_array`

## Requirements
- R1: For slot k with 0 <= k < N, the product bit seen after that slot is bit k of the unsigned product of the multiplicand and the multiplier, where multiplier bit k was driven in slot k.
- R2: For slot k with N <= k < 2N, where zero is driven on the serial input, the product bit seen after that slot is bit k of the same product.
- R3: The product output is registered: the bit formed in slot k appears at the clock edge that ends slot k and stays there until the next edge. Before that edge the output still shows the bit of the previous slot.
- R4: Each cell keeps its own carry from one slot to the next. With both operands at all ones, 2^N-1 squared is produced exactly.
- R5: After 2N slots with zero on the serial input, every carry and every inter-cell sum register is zero. An operation may therefore start in the slot right after the previous one ends and still give an exact product.
- R6: A synchronous, active-high reset clears every carry, every inter-cell sum register and the product output. A reset in the middle of an operation leaves nothing behind that affects the next operation.
- R7: A zero multiplicand or a zero multiplier gives a zero bit in all 2N product slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one slot per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mcand | input | N | Parallel multiplicand, held for the whole operation |
| mplier_bit | input | 1 | Serial multiplier bit for the current slot, zero during flush |
| prod_bit | output | 1 | Serial product bit, least significant first, one clock behind its slot |

## Verification
In one cell and one slot, three events can coincide: a carry stored in the previous slot, a one arriving from the neighbour's sum register, and a one from the gated multiplicand bit. When they meet, the full adder has to keep a carry while it also passes a sum bit on. All-ones operands force this case in every cell, and an exhaustive sweep of operand pairs at N = 4 reaches every mix of carries. The sweep also runs operations with no gap between them, so the last flush slot of one product sits directly next to the first multiplier bit of the next. Every product bit is compared with the same bit of a product that the bench computes with integer arithmetic.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef struct packed {
    logic sum;
    logic cout;
  } fa_res_t;

  // One-bit full adder
  function automatic fa_res_t full_add(input logic a, input logic b, input logic ci);
    fa_res_t r;
    r.sum  = a ^ b ^ ci;
    r.cout = (a & b) | (a & ci) | (b & ci);
    return r;
  endfunction

  // Partial-product bit: multiplicand bit gated by the serial multiplier bit
  function automatic logic pp_bit(input logic x, input logic y);
    return x & y;
  endfunction

endpackage

// File: rtl/spm_link.sv
module spm_link (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

endmodule

// File: rtl/spm_cell.sv
module spm_cell
  import spm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x_bit,
  input  logic y_bit,
  input  logic ps_in,
  output logic ps_out,
  output logic carry_q
);

  logic    pp;
  fa_res_t add_res;

  always_comb begin
    pp      = pp_bit(x_bit, y_bit);
    add_res = full_add(pp, ps_in, carry_q);
  end

  assign ps_out = add_res.sum;

  // Local carry: fed back into this cell's adder in the next slot
  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= add_res.cout;
  end

endmodule

// File: rtl/spm_array.sv
module spm_array #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] mcand,
  input  logic         mplier_bit,
  output logic         prod_bit
);

  localparam int LINKS = N - 1;

  // Named internal events, visible to the bound checker
  logic [N-1:0]     cell_sum;   // combinational sum leaving each cell
  logic [N-1:0]     carry_q;    // carry register of each cell
  logic [N-1:0]     ps_in;      // sum entering each cell
  logic [LINKS-1:0] link_q;     // link_q[j] holds last slot's sum of cell j+1

  generate
    for (genvar j = 0; j < N; j++) begin : g_cell
      spm_cell u_cell (
        .clk     (clk),
        .rst     (rst),
        .x_bit   (mcand[j]),
        .y_bit   (mplier_bit),
        .ps_in   (ps_in[j]),
        .ps_out  (cell_sum[j]),
        .carry_q (carry_q[j])
      );
      if (j == N - 1) begin : g_end
        assign ps_in[j] = 1'b0;
      end else begin : g_mid
        spm_link u_link (
          .clk (clk),
          .rst (rst),
          .d   (cell_sum[j+1]),
          .q   (link_q[j])
        );
        assign ps_in[j] = link_q[j];
      end
    end
  endgenerate

  // Output register on the cell nearest the output
  spm_link u_out (
    .clk (clk),
    .rst (rst),
    .d   (cell_sum[0]),
    .q   (prod_bit)
  );

endmodule

// File: rtl/spm_array_chk.sv
module spm_array_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] mcand,
  input logic         mplier_bit,
  input logic         prod_bit,
  input logic [N-1:0] cell_sum,
  input logic [N-1:0] carry_q,
  input logic [N-2:0] link_q
);

  localparam int DRAIN = 2 * N;
  localparam int CW    = $clog2(DRAIN + 1);

  logic [CW-1:0] zero_run;
  logic          state_zero;

  assign state_zero = (carry_q == '0) && (link_q == '0);

  // Count consecutive zero slots, saturating at 2N
  always_ff @(posedge clk) begin
    if (rst)                             zero_run <= '0;
    else if (mplier_bit)                 zero_run <= '0;
    else if (zero_run != CW'(DRAIN))     zero_run <= zero_run + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (state_zero && !prod_bit)); // R6

  AST_OUT_LAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (prod_bit == $past(cell_sum[0]))); // R3

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (zero_run == CW'(DRAIN)) |-> state_zero); // R5

  AST_ZERO_MCAND: assert property (@(posedge clk) disable iff (rst)
    ((mcand == '0) && state_zero) |=> state_zero); // R7

endmodule

bind spm_array spm_array_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mcand      (mcand),
  .mplier_bit (mplier_bit),
  .prod_bit   (prod_bit),
  .cell_sum   (cell_sum),
  .carry_q    (carry_q),
  .link_q     (link_q)
);

// File: tb/sim_spm_array.sv
module sim_spm_array;

  localparam int TN = 4;
  localparam int PW = 2 * TN;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TN-1:0] mcand = '0;
  logic          mplier_bit = 1'b0;
  logic          prod_bit;

  int    total = 0;
  int    bad   = 0;
  bit    finished = 1'b0;
  bit    pend_v = 1'b0;
  logic  pend_b = 1'b0;
  string pend_tag = "";

  always #5 clk = ~clk;   // 100 MHz

  spm_array #(.N(TN)) u0 (
    .clk        (clk),
    .rst        (rst),
    .mcand      (mcand),
    .mplier_bit (mplier_bit),
    .prod_bit   (prod_bit)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // One slot: at the falling edge, judge the bit from the previous slot, then drive this one
  task automatic slot(input logic [TN-1:0] a, input logic b, input bit nv, input logic nb,
                      input string ntag);
    @(negedge clk);
    if (pend_v) check(pend_tag, prod_bit, pend_b, "product bit");
    mcand      = a;
    mplier_bit = b;
    pend_v     = nv;
    pend_b     = nb;
    pend_tag   = ntag;
  endtask

  // Full operation: N multiplier bits then N zero slots; expected bits from integer product
  task automatic run_op(input int a, input int m, input string base);
    int p;
    p = a * m;
    for (int k = 0; k < PW; k++) begin
      logic  b;
      string tag;
      b   = (k < TN) ? m[k] : 1'b0;
      tag = (base != "") ? base : ((k < TN) ? "R1" : "R2");
      slot(a[TN-1:0], b, 1'b1, p[k], tag);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk);
    check("R6", prod_bit, 1'b0, "output under reset");
    rst = 1'b0;

    // R3: bit of slot 0 is not visible before its edge, and is visible after it
    slot(TN'(1), 1'b1, 1'b1, 1'b1, "R3");
    #1 check("R3", prod_bit, 1'b0, "output before consuming edge");
    for (int k = 1; k < PW; k++) slot(TN'(1), 1'b0, 1'b1, 1'b0, "R3");

    // R7: zero operands
    run_op(0, (1 << TN) - 1, "R7");
    run_op((1 << TN) - 1, 0, "R7");

    // R4: all ones, every cell carrying; R5: next operation with no gap
    run_op((1 << TN) - 1, (1 << TN) - 1, "R4");
    run_op(1, (1 << TN) - 1, "R5");
    run_op((1 << TN) - 1, (1 << TN) - 1, "R4");
    run_op(5, 3, "R5");

    // R1, R2: exhaustive sweep, operations back to back
    for (int a = 0; a < (1 << TN); a++)
      for (int m = 0; m < (1 << TN); m++)
        run_op(a, m, "");

    // R6: reset in the middle of an all-ones operation
    for (int k = 0; k < 3; k++) slot({TN{1'b1}}, 1'b1, 1'b0, 1'b0, "");
    @(negedge clk);
    rst        = 1'b1;
    mplier_bit = 1'b0;
    pend_v     = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R6", prod_bit, 1'b0, "output after mid-operation reset");
    run_op(9, 11, "R6");
    run_op(13, 14, "R6");

    slot('0, 1'b0, 1'b0, 1'b0, "");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule